// File: doc/BRIEF.md
# Smart-Card Capable Serial Status Register

This block is the byte-wide status register of a serial port that can also run in smart-card mode. Seven flags live in it: transmit buffer empty, receive buffer full, overrun, error-signal status (framing error outside smart-card mode), parity error, transmit end and received multiprocessor bit. An eighth bit holds the multiprocessor bit that software wants transmitted. The shift engines pulse the event inputs for one cycle to set flags. Software reads the register and clears a flag by writing 0 to it.

A clearable flag only drops after a clear handshake. The CPU must first read it as 1, which arms that bit. A later write of 0 to the armed bit clears the flag and disarms the bit. In smart-card mode, bit 4 records that the far end pulled the line low to report a parity error during transmission, and framing events are ignored. Outside smart-card mode, bit 4 is a framing-error flag. A low-power input (standby or module stop) clears the error-signal flag.

Top module: `sc_status_reg`

## Requirements
- R1: After reset, `rdData` reads 0x84: bit 7 (transmit empty) and bit 2 (transmit end) are 1, and every other bit is 0.
- R2: The bit positions are: 7 transmit empty, 6 receive full, 5 overrun, 4 error signal / framing, 3 parity, 2 transmit end, 1 received multiprocessor bit, 0 transmit multiprocessor bit. `rdData` always shows the current register.
- R3: A one-cycle pulse on `evTxEmpty`, `evRxFull`, `evOverrun`, `evParity` or `evTxEnd` sets bit 7, 6, 5, 3 or 2 respectively. The bit is visible on `rdData` in the following cycle.
- R4: A write of 0 to any of bits 7..3 leaves that flag unchanged unless a read (`rdStrobe`) in an earlier cycle returned 1 in that bit.
- R5: A write of 0 to an armed bit among 7..3 clears the flag. It also disarms the bit, so after the flag is set again, a further write of 0 without a new read has no effect.
- R6: Writing 1 to any of bits 7..3 never changes that bit.
- R7: If a set event and a valid clear hit the same bit in the same cycle, the bit ends up 1.
- R8: With `scMode`=1, `evErrSigLow` sets bit 4 only while `txEnable`=1, and `evFraming` has no effect.
- R9: With `scMode`=0, `evFraming` sets bit 4 and `evErrSigLow` has no effect.
- R10: `lowPower`=1 clears bit 4 in the next cycle. It also drops bit 4's arm, so a later write of 0 without a new read leaves a re-set bit 4 at 1.
- R11: Lowering `txEnable` leaves bit 4 unchanged.
- R12: Bits 2 and 1 are read-only. Bit 2 is cleared only by `evTxStart`. Bit 1 loads `rxMpb` when `evRxFull` pulses.
- R13: Bit 0 is read/write and takes `wrData[0]` on every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowPower | input | 1 | Standby or module-stop request |
| scMode | input | 1 | 1 selects smart-card mode |
| txEnable | input | 1 | Transmit enable |
| rdStrobe | input | 1 | CPU read of the register this cycle |
| wrStrobe | input | 1 | CPU write of the register this cycle |
| wrData | input | 8 | CPU write data |
| evTxEmpty | input | 1 | Transmit buffer became empty |
| evRxFull | input | 1 | Receive buffer became full |
| evOverrun | input | 1 | Receive overrun detected |
| evErrSigLow | input | 1 | Low level of the returned error signal sampled |
| evFraming | input | 1 | Framing error detected |
| evParity | input | 1 | Parity error detected |
| evTxEnd | input | 1 | Transmission ended |
| evTxStart | input | 1 | New transmission started |
| rxMpb | input | 1 | Multiprocessor bit of the received frame |
| rdData | output | 8 | Register contents |

## Verification
Every event, write, read arm and low-power request acts at one clock edge. Its effect appears on `rdData` exactly one cycle later, since only the flag register lies between input and output. A read arms a bit at its edge, so the clearing write may follow in the very next cycle. The bench drives each stimulus just after a falling edge and compares `rdData` at the following falling edge, once the one rising edge between them has updated the register.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;
  localparam int REG_W    = 8;
  localparam int TDRE_BIT = 7;
  localparam int RDRF_BIT = 6;
  localparam int OVR_BIT  = 5;
  localparam int ERS_BIT  = 4;
  localparam int PAR_BIT  = 3;
  localparam int TEND_BIT = 2;
  localparam int MPB_BIT  = 1;
  localparam int MPBT_BIT = 0;
  // clearable flags occupy the contiguous range CLR_LO..CLR_HI
  localparam int CLR_LO   = PAR_BIT;
  localparam int CLR_HI   = TDRE_BIT;
  localparam logic [REG_W-1:0] RESET_VALUE =
    REG_W'((1 << TDRE_BIT) | (1 << TEND_BIT));

  typedef struct packed {
    logic [REG_W-1:0] setBits;
    logic [REG_W-1:0] clrBits;
    logic             mpbLoad;
    logic             mpbValue;
    logic             mpbtLoad;
    logic             mpbtValue;
  } strobes_t;
endpackage

// File: rtl/sc_status_ctrl.sv
module sc_status_ctrl
  import sc_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowPower,
  input  logic             scMode,
  input  logic             txEnable,
  input  logic             rdStrobe,
  input  logic             wrStrobe,
  input  logic [REG_W-1:0] wrData,
  input  logic             evTxEmpty,
  input  logic             evRxFull,
  input  logic             evOverrun,
  input  logic             evErrSigLow,
  input  logic             evFraming,
  input  logic             evParity,
  input  logic             evTxEnd,
  input  logic             evTxStart,
  input  logic             rxMpb,
  input  logic [REG_W-1:0] flagsIn,
  output strobes_t         strobes
);
  logic [REG_W-1:0]   setVec;
  logic [REG_W-1:0]   clrVec;
  logic [CLR_HI:CLR_LO] armBits;
  logic               roWriteUnused;

  // bits 2 and 1 are read-only; their write data is dropped
  assign roWriteUnused = ^wrData[TEND_BIT:MPB_BIT];

  always_comb begin
    setVec           = '0;
    setVec[TDRE_BIT] = evTxEmpty;
    setVec[RDRF_BIT] = evRxFull;
    setVec[OVR_BIT]  = evOverrun;
    setVec[ERS_BIT]  = ~lowPower & (scMode ? (evErrSigLow & txEnable) : evFraming);
    setVec[PAR_BIT]  = evParity;
    setVec[TEND_BIT] = evTxEnd;
  end

  assign clrVec[TEND_BIT] = evTxStart & ~evTxEnd;
  assign clrVec[MPB_BIT]  = 1'b0;
  assign clrVec[MPBT_BIT] = 1'b0;

  for (genvar i = CLR_LO; i <= CLR_HI; i++) begin : g_clr
    localparam bit IS_ERS = (i == ERS_BIT);
    logic armQ;
    logic wrClear;
    logic pwrClear;

    assign pwrClear  = IS_ERS & lowPower;
    assign wrClear   = wrStrobe & ~wrData[i] & armQ;
    assign clrVec[i] = (wrClear & ~setVec[i]) | pwrClear;
    assign armBits[i] = armQ;

    always_ff @(posedge clk) begin
      if (!rstN)                    armQ <= 1'b0;
      else if (wrClear || pwrClear) armQ <= 1'b0;
      else if (rdStrobe && flagsIn[i]) armQ <= 1'b1;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.setBits   = setVec;
    strobes.clrBits   = clrVec;
    strobes.mpbLoad   = evRxFull;
    strobes.mpbValue  = rxMpb;
    strobes.mpbtLoad  = wrStrobe;
    strobes.mpbtValue = wrData[MPBT_BIT];
  end

  AST_NO_CLEAR_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !lowPower && armBits == '0) |=>
      ((~flagsIn[CLR_HI:CLR_LO] & $past(flagsIn[CLR_HI:CLR_LO])) == '0)); // R4

  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !lowPower && (&wrData[CLR_HI:CLR_LO])) |=>
      ((~flagsIn[CLR_HI:CLR_LO] & $past(flagsIn[CLR_HI:CLR_LO])) == '0)); // R6

  AST_LOWPOWER_ERS: assert property (@(posedge clk) disable iff (!rstN)
    lowPower |=> !flagsIn[ERS_BIT]); // R10

  AST_SC_FRAMING_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (scMode && !evErrSigLow && !flagsIn[ERS_BIT]) |=> !flagsIn[ERS_BIT]); // R8
endmodule

// File: rtl/sc_status_dp.sv
module sc_status_dp
  import sc_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  output logic [REG_W-1:0] flagsOut
);
  logic [REG_W-1:0] flagsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= RESET_VALUE;
    end else begin
      flagsQ[CLR_HI:TEND_BIT] <= (flagsQ[CLR_HI:TEND_BIT] & ~strobes.clrBits[CLR_HI:TEND_BIT])
                               | strobes.setBits[CLR_HI:TEND_BIT];
      if (strobes.mpbLoad)  flagsQ[MPB_BIT]  <= strobes.mpbValue;
      if (strobes.mpbtLoad) flagsQ[MPBT_BIT] <= strobes.mpbtValue;
    end
  end

  assign flagsOut = flagsQ;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setBits != '0) |=>
      ((flagsQ & $past(strobes.setBits)) == $past(strobes.setBits))); // R7

  AST_TEND_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagsQ[TEND_BIT]) |-> $past(strobes.clrBits[TEND_BIT])); // R12
endmodule

// File: rtl/sc_status_reg.sv
module sc_status_reg
  import sc_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowPower,
  input  logic             scMode,
  input  logic             txEnable,
  input  logic             rdStrobe,
  input  logic             wrStrobe,
  input  logic [REG_W-1:0] wrData,
  input  logic             evTxEmpty,
  input  logic             evRxFull,
  input  logic             evOverrun,
  input  logic             evErrSigLow,
  input  logic             evFraming,
  input  logic             evParity,
  input  logic             evTxEnd,
  input  logic             evTxStart,
  input  logic             rxMpb,
  output logic [REG_W-1:0] rdData
);
  strobes_t         strobes;
  logic [REG_W-1:0] flags;

  sc_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .scMode(scMode),
    .txEnable(txEnable), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .wrData(wrData), .evTxEmpty(evTxEmpty), .evRxFull(evRxFull),
    .evOverrun(evOverrun), .evErrSigLow(evErrSigLow), .evFraming(evFraming),
    .evParity(evParity), .evTxEnd(evTxEnd), .evTxStart(evTxStart),
    .rxMpb(rxMpb), .flagsIn(flags), .strobes(strobes)
  );

  sc_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .flagsOut(flags)
  );

  assign rdData = flags;
endmodule

// File: tb/sc_status_reg_tb.sv
module sc_status_reg_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       lowPower, scMode, txEnable, rdStrobe, wrStrobe;
  logic [7:0] wrData;
  logic       evTxEmpty, evRxFull, evOverrun, evErrSigLow, evFraming;
  logic       evParity, evTxEnd, evTxStart, rxMpb;
  logic [7:0] rdData;
  int         checks = 0;
  int         fails  = 0;

  always #2 clk = ~clk; // 4 ns period, 250 MHz

  sc_status_reg u_dut (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .scMode(scMode),
    .txEnable(txEnable), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .wrData(wrData), .evTxEmpty(evTxEmpty), .evRxFull(evRxFull),
    .evOverrun(evOverrun), .evErrSigLow(evErrSigLow), .evFraming(evFraming),
    .evParity(evParity), .evTxEnd(evTxEnd), .evTxStart(evTxStart),
    .rxMpb(rxMpb), .rdData(rdData)
  );

  // vector: events[27:20] (0 txEmpty,1 rxFull,2 overrun,3 errSig,4 framing,
  // 5 parity,6 txEnd,7 txStart), ctl[19:16] {scMode,txEnable,rd,wr},
  // wrData[15:8], expected rdData[7:0]
  localparam int NVEC = 20;
  localparam logic [27:0] VEC [NVEC] = '{
    {8'h00, 4'b1101, 8'h00, 8'h84},  // R4 write 0 unarmed
    {8'h00, 4'b1110, 8'h00, 8'h84},  // R2 read arms bit 7
    {8'h00, 4'b1101, 8'h00, 8'h04},  // R5 armed clear
    {8'h01, 4'b1100, 8'h00, 8'h84},  // R3 tx empty
    {8'h00, 4'b1101, 8'h00, 8'h84},  // R5 arm dropped
    {8'h22, 4'b1100, 8'h00, 8'hCC},  // R3 rx full + parity
    {8'h00, 4'b1110, 8'h00, 8'hCC},  // R2 read arms 7,6,3
    {8'h00, 4'b1101, 8'hFF, 8'hCD},  // R6 ones ignored, R13 bit0
    {8'h00, 4'b1101, 8'hB7, 8'h85},  // R5 clear 6 and 3
    {8'h08, 4'b1100, 8'h00, 8'h95},  // R8 error signal
    {8'h10, 4'b1100, 8'h00, 8'h95},  // R8 framing ignored
    {8'h00, 4'b1000, 8'h00, 8'h95},  // R11 TE low keeps bit 4
    {8'h00, 4'b1110, 8'h00, 8'h95},  // R2 read arms 7,4
    {8'h01, 4'b1101, 8'h00, 8'h84},  // R7 set wins on bit 7
    {8'h00, 4'b1101, 8'h00, 8'h84},  // R5 bit 7 disarmed
    {8'h08, 4'b0100, 8'h00, 8'h84},  // R9 error signal ignored
    {8'h10, 4'b0100, 8'h00, 8'h94},  // R9 framing sets bit 4
    {8'h80, 4'b0100, 8'h00, 8'h90},  // R12 tx start clears TEND
    {8'h40, 4'b0100, 8'h00, 8'h94},  // R3 tx end
    {8'h04, 4'b0100, 8'h00, 8'hB4}   // R3 overrun
  };

  task automatic idle();
    lowPower = 0; rdStrobe = 0; wrStrobe = 0; wrData = 8'h00;
    evTxEmpty = 0; evRxFull = 0; evOverrun = 0; evErrSigLow = 0;
    evFraming = 0; evParity = 0; evTxEnd = 0; evTxStart = 0;
  endtask

  task automatic check(input string req, input logic [7:0] expected);
    checks++;
    if (rdData !== expected) begin
      fails++;
      $display("FAIL %s: rdData actual=%h expected=%h", req, rdData, expected);
    end
  endtask

  task automatic step(); // one rising edge, return at the next falling edge
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog (R1..R13): actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(); scMode = 1; txEnable = 1; rxMpb = 0; rstN = 0;
    repeat (3) @(negedge clk);
    check("R1", 8'h84);
    rstN = 1;
    step();
    check("R1", 8'h84);

    for (int v = 0; v < NVEC; v++) begin
      idle();
      {evTxStart, evTxEnd, evParity, evFraming, evErrSigLow,
       evOverrun, evRxFull, evTxEmpty} = VEC[v][27:20];
      {scMode, txEnable, rdStrobe, wrStrobe} = VEC[v][19:16];
      wrData = VEC[v][15:8];
      step();
      check($sformatf("vector %0d (R2)", v), VEC[v][7:0]);
    end

    // R10: low power clears bit 4 and drops its arm
    idle(); scMode = 1; txEnable = 1; rdStrobe = 1;
    step(); check("R10 read", 8'hB4);
    idle(); lowPower = 1;
    step(); check("R10", 8'hA4);
    idle(); evErrSigLow = 1;
    step(); check("R8", 8'hB4);
    idle(); wrStrobe = 1; wrData = 8'hA0;
    step(); check("R10 arm dropped", 8'hB4);

    // R12: bit 1 loads rxMpb; bit 2 ignores a written 0 after a read
    idle(); rxMpb = 1; evRxFull = 1;
    step(); check("R12 mpb", 8'hF6);
    idle(); rdStrobe = 1;
    step(); check("R12 read", 8'hF6);
    idle(); wrStrobe = 1; wrData = 8'hFB;
    step(); check("R12 tend read-only", 8'hF7);

    // R13: bit 0 written back to 0
    idle(); wrStrobe = 1; wrData = 8'hFE;
    step(); check("R13", 8'hF6);

    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule